// File: doc/BRIEF.md
# Per-Channel Data Word Limiter

This block sits in a front-end readout path and caps the number of data words that each channel frame may carry. A frame opens with a begin word, carries any number of data words and closes with an end word. Data words past a programmable limit are discarded in flight. The begin and end words are always forwarded, and the word-count field of the end word is rewritten to the number of data words that actually left the block. An oversized frame therefore arrives downstream shortened but well formed. The path never stops and no event is aborted.

Words enter and leave on valid/ready handshakes, through one output register. A separate write port loads the limit. The block flags every end word of a shortened frame. It also keeps a saturating count of words that arrive outside any frame.

Top module: `wordcap_limiter`

## Requirements
- R1: Bits [31:30] of a word give its kind: 2'b10 is a begin word, 2'b11 is an end word, and 2'b00 or 2'b01 is a data word.
- R2: After reset the output is empty (out_valid low), err_count is 0 and the limit field is 0x060, so a frame forwards at most 96 data words.
- R3: Let L be the limit field value, with 0 standing for 4096. A frame with N data words forwards the first min(N, L) of them, in order and unchanged, and discards the rest.
- R4: Begin and end words of a frame are always forwarded. In an end word, bits [11:0] are replaced by the number of data words forwarded in that frame, modulo 4096, and bits [31:12] are kept.
- R5: out_trunc is high together with an end word exactly when that frame discarded at least one data word. It is low with every other word.
- R6: The limit is captured when a begin word is accepted. A write during a frame takes effect from the next begin word.
- R7: A data word or end word accepted while no frame is open is discarded and increments err_count. err_count saturates at its maximum value.
- R8: in_ready is high whenever the output register is empty or out_ready is high, and it is high for discarded words as well. A forwarded word is on the output in the cycle after it is accepted.
- R9: While out_valid is high and out_ready is low, out_data and out_trunc hold their values.
- R10: A begin word that arrives inside an open frame starts a new frame: the count, the limit and the truncation flag restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output word |
| out_trunc | output | 1 | Frame of this end word was shortened |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 12 | Limit value; 0 means 4096 |
| err_count | output | 8 | Saturating count of out-of-frame words |

## Verification
Several properties are checked on every cycle by the assertions. The per-frame count never passes its captured limit. The limit holds between writes. The error count never falls. A stalled output holds its value. The truncation flag appears only on end words. A begin word always reaches the output one cycle later. The bench scenarios are needed for the rest: the exact word sequence of a shortened frame, the rewritten count (including the 4096 wrap to zero), the timing of a limit write during a frame, restart on a repeated begin word, and counter saturation. All of these are compared against a transaction-level model under random frames and random back-pressure.

// File: rtl/wordcap_pkg.sv
`timescale 1ns/1ps
package wordcap_pkg;
  typedef enum logic [1:0] {
    K_DATA  = 2'd0,
    K_BEGIN = 2'd1,
    K_END   = 2'd2
  } word_kind_e;

  // R1: kind tag lives in the two most significant bits
  function automatic word_kind_e kind_of(input logic [1:0] tag);
    case (tag)
      2'b10:   kind_of = K_BEGIN;
      2'b11:   kind_of = K_END;
      default: kind_of = K_DATA;
    endcase
  endfunction
endpackage

// File: rtl/wordcap_limit_reg.sv
`timescale 1ns/1ps
module wordcap_limit_reg #(
  parameter int unsigned          CW      = 12,
  parameter logic [CW-1:0]        LIM_RST = 12'h060
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW:0]   lim_eff
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic [CW-1:0] field_q, field_d;

  always_comb begin
    field_d = field_q;
    if (we) field_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= LIM_RST;
    else        field_q <= field_d;
  end

  assign lim_eff = (field_q == '0) ? FULL : {1'b0, field_q};

  AST_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(field_q)); // R6
  AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_eff != '0) && (lim_eff <= FULL)); // R3
endmodule

// File: rtl/wordcap_frame_ctl.sv
`timescale 1ns/1ps
module wordcap_frame_ctl
  import wordcap_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 12,
  parameter int unsigned ECW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic [DW-1:0]  din,
  input  logic [CW:0]    lim_eff,
  output logic           fwd,
  output logic [DW-1:0]  fwd_data,
  output logic           fwd_trunc,
  output logic [ECW-1:0] err_cnt
);
  logic           open_q, open_d;
  logic [CW:0]    cnt_q, cnt_d;
  logic [CW:0]    cap_q, cap_d;
  logic           cut_q, cut_d;
  logic [ECW-1:0] err_q, err_d;
  logic           orphan;

  always_comb begin
    open_d    = open_q;
    cnt_d     = cnt_q;
    cap_d     = cap_q;
    cut_d     = cut_q;
    err_d     = err_q;
    fwd       = 1'b0;
    fwd_data  = din;
    fwd_trunc = 1'b0;
    orphan    = 1'b0;
    if (acc) begin
      case (kind_of(din[DW-1:DW-2]))
        K_BEGIN: begin
          open_d = 1'b1;
          cnt_d  = '0;
          cap_d  = lim_eff;
          cut_d  = 1'b0;
          fwd    = 1'b1;
        end
        K_END: begin
          if (open_q) begin
            fwd       = 1'b1;
            fwd_data  = {din[DW-1:CW], cnt_q[CW-1:0]};
            fwd_trunc = cut_q;
            open_d    = 1'b0;
          end else begin
            orphan = 1'b1;
          end
        end
        default: begin
          if (!open_q) begin
            orphan = 1'b1;
          end else if (cnt_q < cap_q) begin
            fwd   = 1'b1;
            cnt_d = cnt_q + 1'b1;
          end else begin
            cut_d = 1'b1;
          end
        end
      endcase
    end
    if (orphan && (err_q != '1)) err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      cap_q  <= '0;
      cut_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      cut_q  <= cut_d;
      err_q  <= err_d;
    end
  end

  assign err_cnt = err_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt_q <= cap_q)); // R3
  AST_ERR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_q >= $past(err_q))); // R7
endmodule

// File: rtl/wordcap_out_stage.sv
`timescale 1ns/1ps
module wordcap_out_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_trunc,
  input  logic          out_ready,
  output logic          slot_free,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_trunc
);
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          trc_q, trc_d;

  assign slot_free = !vld_q || out_ready;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    trc_d = trc_q;
    if (load) begin
      vld_d = 1'b1;
      dat_d = ld_data;
      trc_d = ld_trunc;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      trc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      trc_q <= trc_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_trunc = trc_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_trunc))); // R9
endmodule

// File: rtl/wordcap_limiter.sv
`timescale 1ns/1ps
module wordcap_limiter #(
  parameter int unsigned   DW      = 32,
  parameter int unsigned   CW      = 12,
  parameter int unsigned   ECW     = 8,
  parameter logic [CW-1:0] LIM_RST = 12'h060
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_trunc,
  input  logic           lim_we,
  input  logic [CW-1:0]  lim_wdata,
  output logic [ECW-1:0] err_count
);
  logic [CW:0]   lim_eff;
  logic          acc;
  logic          fwd;
  logic [DW-1:0] fwd_data;
  logic          fwd_trunc;
  logic          slot_free;

  assign in_ready = slot_free;
  assign acc      = in_valid && slot_free;

  wordcap_limit_reg #(.CW(CW), .LIM_RST(LIM_RST)) u_limit (
    .clk(clk), .rst_n(rst_n), .we(lim_we), .wdata(lim_wdata), .lim_eff(lim_eff)
  );

  wordcap_frame_ctl #(.DW(DW), .CW(CW), .ECW(ECW)) u_frame (
    .clk(clk), .rst_n(rst_n), .acc(acc), .din(in_data), .lim_eff(lim_eff),
    .fwd(fwd), .fwd_data(fwd_data), .fwd_trunc(fwd_trunc), .err_cnt(err_count)
  );

  wordcap_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(fwd), .ld_data(fwd_data), .ld_trunc(fwd_trunc),
    .out_ready(out_ready), .slot_free(slot_free), .out_valid(out_valid),
    .out_data(out_data), .out_trunc(out_trunc)
  );

  AST_TRUNC_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trunc) |-> (out_data[DW-1:DW-2] == 2'b11)); // R5
  AST_BEGIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_data[DW-1:DW-2] == 2'b10))
      |=> (out_valid && (out_data == $past(in_data)))); // R4
endmodule

// File: tb/wordcap_limiter_bench.sv
`timescale 1ns/1ps
module wordcap_limiter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_trunc;
  logic        lim_we;
  logic [11:0] lim_wdata;
  logic [7:0]  err_count;

  always #2 clk = ~clk;

  wordcap_limiter u_wordcap_limiter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_trunc(out_trunc), .lim_we(lim_we),
    .lim_wdata(lim_wdata), .err_count(err_count)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [32:0] expq[$];
  int   m_lim = 12'h060;
  bit   m_open = 0;
  int   m_cnt = 0;
  int   m_cap = 0;
  bit   m_cut = 0;
  int   m_err = 0;
  bit   last_acc;
  bit   s_vld;
  logic [31:0] s_dat;
  int   last_end_cnt = -1;
  bit   last_end_trc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int f);
    return (f == 0) ? 4096 : f;
  endfunction

  task automatic model_accept(input logic [31:0] d);
    case (d[31:30])
      2'b10: begin
        m_open = 1; m_cnt = 0; m_cap = eff(m_lim); m_cut = 0;
        expq.push_back({1'b0, d});
      end
      2'b11: begin
        if (!m_open) begin
          if (m_err < 255) m_err++;
        end else begin
          expq.push_back({m_cut, d[31:12], 12'(m_cnt)});
          m_open = 0;
        end
      end
      default: begin
        if (!m_open) begin
          if (m_err < 255) m_err++;
        end else if (m_cnt < m_cap) begin
          expq.push_back({1'b0, d});
          m_cnt++;
        end else begin
          m_cut = 1;
        end
      end
    endcase
  endtask

  task automatic step(input bit v, input logic [31:0] d, input bit rdy,
                      input bit we, input logic [11:0] wd);
    logic [32:0] e;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = rdy; lim_we = we; lim_wdata = wd;
    #1;
    s_vld = out_valid; s_dat = out_data;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R3", "unexpected output word", longint'(out_data), 0);
      end else begin
        e = expq.pop_front();
        if (e[31:30] == 2'b11) begin
          last_end_cnt = int'(out_data[11:0]);
          last_end_trc = out_trunc;
          chk(out_data == e[31:0], "R4", "end word", longint'(out_data), longint'(e[31:0]));
          chk(out_trunc == e[32], "R5", "trunc flag on end", longint'(out_trunc), longint'(e[32]));
        end else if (e[31:30] == 2'b10) begin
          chk(out_data == e[31:0], "R4", "begin word", longint'(out_data), longint'(e[31:0]));
          chk(out_trunc == 1'b0, "R5", "trunc flag on begin", longint'(out_trunc), 0);
        end else begin
          chk(out_data == e[31:0], "R3", "data word", longint'(out_data), longint'(e[31:0]));
          chk(out_trunc == 1'b0, "R5", "trunc flag on data", longint'(out_trunc), 0);
        end
      end
    end
    last_acc = in_valid && in_ready;
    if (last_acc) model_accept(d);
    if (we) m_lim = int'(wd);
  endtask

  task automatic send(input logic [31:0] d, input bit rand_rdy);
    bit r;
    do begin
      r = rand_rdy ? (($urandom % 10) < 7) : 1'b1;
      step(1, d, r, 0, 0);
    end while (!last_acc);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (expq.size() != 0 || out_valid); i++) step(0, 32'h0, 1, 0, 0);
    step(0, 32'h0, 1, 0, 0);
  endtask

  task automatic write_lim(input logic [11:0] v);
    step(0, 32'h0, 1, 1, v);
  endtask

  function automatic logic [31:0] dword();
    logic [31:0] w = $urandom;
    w[31] = 1'b0;
    return w;
  endfunction

  task automatic frame(input int n, input bit rr);
    send({2'b10, 30'($urandom)}, rr);
    for (int i = 0; i < n; i++) send(dword(), rr);
    send({2'b11, 18'($urandom), 12'hABC}, rr);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; in_valid = 0; in_data = 0; out_ready = 0; lim_we = 0; lim_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R2", "out_valid after reset", longint'(out_valid), 0);
    chk(err_count == 0, "R2", "err_count after reset", longint'(err_count), 0);
    chk(in_ready == 1, "R8", "in_ready when empty", longint'(in_ready), 1);

    // R2: default limit 96 caps a 100-word frame
    frame(100, 0); drain();
    chk(last_end_cnt == 96, "R2", "default limit count", last_end_cnt, 96);
    chk(last_end_trc == 1, "R5", "default limit trunc", longint'(last_end_trc), 1);

    // R3: limit 4, five data words
    write_lim(12'd4);
    frame(5, 0); drain();
    chk(last_end_cnt == 4, "R3", "limit 4 count", last_end_cnt, 4);
    frame(4, 0); drain();
    chk(last_end_trc == 0, "R5", "exact fit not truncated", longint'(last_end_trc), 0);
    frame(0, 0); drain();
    chk(last_end_cnt == 0, "R4", "empty frame count", last_end_cnt, 0);

    // R3: limit 1
    write_lim(12'd1);
    frame(3, 1); drain();
    chk(last_end_cnt == 1, "R3", "limit 1 count", last_end_cnt, 1);

    // R3/R4: field 0 means 4096, count wraps to 0
    write_lim(12'd0);
    frame(4100, 0); drain();
    chk(last_end_cnt == 0, "R4", "4096 count wraps", last_end_cnt, 0);
    chk(last_end_trc == 1, "R3", "4100 words truncated at 4096", longint'(last_end_trc), 1);

    // R6: write mid-frame applies to next frame
    write_lim(12'd8);
    send({2'b10, 30'h1}, 0);
    send(dword(), 0); send(dword(), 0);
    write_lim(12'd3);
    for (int i = 0; i < 6; i++) send(dword(), 0);
    send({2'b11, 30'h0}, 0); drain();
    chk(last_end_cnt == 8, "R6", "old limit kept in frame", last_end_cnt, 8);
    frame(5, 0); drain();
    chk(last_end_cnt == 3, "R6", "new limit next frame", last_end_cnt, 3);

    // R10: begin inside a frame restarts it
    send({2'b10, 30'h2}, 0);
    send(dword(), 0); send(dword(), 0); send(dword(), 0); send(dword(), 0);
    frame(2, 0); drain();
    chk(last_end_cnt == 2, "R10", "restart count", last_end_cnt, 2);
    chk(last_end_trc == 0, "R10", "restart clears trunc", longint'(last_end_trc), 0);

    // R8: one-cycle latency
    step(1, {2'b10, 30'h3}, 1, 0, 0);
    step(0, 32'h0, 1, 0, 0);
    chk(s_vld && s_dat == {2'b10, 30'h3}, "R8", "latency one cycle", longint'(s_dat), longint'({2'b10, 30'h3}));
    // R9: hold under back-pressure
    step(1, {2'b11, 30'h0}, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 32'h0, 0, 0, 0);
      chk(s_vld && s_dat[31:30] == 2'b11, "R9", "held end word", longint'(s_dat), longint'({2'b11, 30'h0}));
    end
    drain();

    // R7: orphans counted and saturate
    send(dword(), 0); send({2'b11, 30'h5}, 0); drain();
    chk(err_count == 8'd2, "R7", "orphan count", longint'(err_count), 2);
    chk(expq.size() == 0 && !out_valid, "R7", "orphans not forwarded", longint'(out_valid), 0);
    for (int i = 0; i < 260; i++) send(dword(), 0);
    drain();
    chk(err_count == 8'd255, "R7", "saturation", longint'(err_count), 255);

    // random frames, random back-pressure
    for (int f = 0; f < 250; f++) begin
      if (($urandom % 8) == 0) write_lim(12'($urandom % 12));
      if (($urandom % 20) == 0) send(dword(), 1);
      frame(int'($urandom % 14), 1);
    end
    drain();
    chk(expq.size() == 0, "R3", "all expected words seen", expq.size(), 0);
    chk(err_count == 8'(m_err), "R7", "err_count after random", longint'(err_count), longint'(m_err));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule